// File: doc/BRIEF.md
# Periodic Interval Timer with Byte Register Access

This block produces a repeating interrupt request at a programmable interval. A 16-bit up-counter advances on ticks from a binary prescaler fed by the bus clock. When the counter has reached a 16-bit limit value, the next tick returns it to zero and raises an overflow flag. The flag drives an interrupt request while the interrupt enable is set.

Software controls the timer through five byte-wide registers. The control/status byte sits at offset 0. The read-only counter is at offsets 1 (high byte) and 2 (low byte), and the limit is at offsets 3 (high byte) and 4 (low byte). Writes happen on a single-cycle strobe. Reads are combinational on the offset. After reset the timer is halted, so software must clear the halt bit before any counting starts.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control byte reads 0x20, the counter reads 0x0000, the limit reads 0xFFFF, the interrupt request is low, and the counter does not advance.
- R2: The control byte at offset 0 has this layout: bit 7 overflow flag, bit 6 interrupt enable, bit 5 halt, bit 4 counter-clear strobe, bit 3 unused, bits 2:0 rate select. Bits 4 and 3 always read 0, and offsets 5 to 7 read 0x00.
- R3: Rate select codes 0 to 6 advance the counter once every 1, 2, 4, 8, 16, 32 and 64 bus cycles. Code 7 gives the same rate as code 6.
- R4: While the halt bit is 0, each prescaled tick increments the counter by one.
- R5: A tick that arrives while the counter equals the limit loads the counter with 0x0000 and sets the overflow flag.
- R6: While the halt bit is 1, the counter and the prescaler keep their values. Clearing the halt bit resumes counting from those held values.
- R7: Writing a 1 to bit 4 of the control byte clears the counter and the prescaler in the same cycle. The bit is not stored.
- R8: Writing 0 to bit 7 of the control byte clears the overflow flag. Writing 1 to bit 7 leaves the flag unchanged.
- R9: If a wrap and a software clear of the flag fall in the same cycle, the flag ends at 1.
- R10: The interrupt request is high exactly while the overflow flag and the interrupt enable are both 1.
- R11: Writes to offsets 1 and 2 do not change the counter.
- R12: Each limit byte (offset 3 high, offset 4 low) can be written and read back independently of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims software flag clears at the exact cycle of a wrap. A design where the clear wins loses the interrupt. It issues a counter-clear strobe partway through a prescaler period. A design that left the prescaler running would deliver the next tick several cycles early. Rate code 7 is checked against the divide-by-64 period, which catches a decoder that wraps to divide-by-1 or goes silent. The halt test counts the tick taken on the same edge as the halting write, which exposes an off-by-one in how halt takes effect.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int CNT_W    = 16;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int RSEL_W   = 3;
  localparam int DIV_LOG  = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CNTH  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CNTL  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LIMH  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_LIML  = 3'd4;

  localparam int B_FLAG  = 7;
  localparam int B_IE    = 6;
  localparam int B_HALT  = 5;
  localparam int B_CLR   = 4;

  typedef struct packed {
    logic              flag;
    logic              ie;
    logic              halt;
    logic [RSEL_W-1:0] rsel;
  } ctrl_t;
endpackage

// File: rtl/ptmr_presc.sv
module ptmr_presc #(
  parameter int RSEL_W  = 3,
  parameter int DIV_LOG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [RSEL_W-1:0] rsel,
  output logic              tick
);
  localparam int PW = DIV_LOG;

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] mask;
  logic [RSEL_W-1:0] eff;

  always_comb begin
    eff = (int'(rsel) > DIV_LOG) ? RSEL_W'(DIV_LOG) : rsel;
  end

  for (genvar gi = 0; gi < PW; gi++) begin : g_mask
    assign mask[gi] = (gi < int'(eff));
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_comb begin
    pre_d = pre_q;
    if (clr)      pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R6
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));

  // R7
  pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             halt,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_lim;

  assign at_lim = (cnt_q == limit);
  assign wrap   = tick && at_lim && !clr;
  assign cnt    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (tick) begin
      if (at_lim)    cnt_d = '0;
      else           cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  limit,
  output logic              cnt_clr
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             we, we_ctrl, we_limh, we_liml;

  assign we      = bus_sel && bus_wr;
  assign we_ctrl = we && (bus_addr == OFS_CTRL);
  assign we_limh = we && (bus_addr == OFS_LIMH);
  assign we_liml = we && (bus_addr == OFS_LIML);
  assign cnt_clr = we_ctrl && bus_wdata[B_CLR];

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_ctrl) begin
      ctrl_d.ie   = bus_wdata[B_IE];
      ctrl_d.halt = bus_wdata[B_HALT];
      ctrl_d.rsel = bus_wdata[RSEL_W-1:0];
      if (!bus_wdata[B_FLAG]) ctrl_d.flag = 1'b0;
    end
    if (wrap) ctrl_d.flag = 1'b1;
  end

  always_comb begin
    lim_d = lim_q;
    if (we_limh) lim_d[CNT_W-1:DATA_W] = bus_wdata;
    if (we_liml) lim_d[DATA_W-1:0]     = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{flag: 1'b0, ie: 1'b0, halt: 1'b1, rsel: '0};
      lim_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      lim_q  <= lim_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign limit = lim_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = {ctrl_q.flag, ctrl_q.ie, ctrl_q.halt, 2'b00, ctrl_q.rsel};
      OFS_CNTH: bus_rdata = cnt[CNT_W-1:DATA_W];
      OFS_CNTL: bus_rdata = cnt[DATA_W-1:0];
      OFS_LIMH: bus_rdata = lim_q[CNT_W-1:DATA_W];
      OFS_LIML: bus_rdata = lim_q[DATA_W-1:0];
      default:  bus_rdata = '0;
    endcase
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ctrl_q.flag);

  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.flag) |-> $past(wrap));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] limit, cnt;
  logic             cnt_clr, tick, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ptmr_regs u_regs (
    .clk(clk), .rst_n(rst_i_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .wrap(wrap), .ctrl(ctrl), .limit(limit), .cnt_clr(cnt_clr)
  );

  ptmr_presc #(.RSEL_W(RSEL_W), .DIV_LOG(DIV_LOG)) u_presc (
    .clk(clk), .rst_n(rst_i_n), .run(!ctrl.halt), .clr(cnt_clr),
    .rsel(ctrl.rsel), .tick(tick)
  );

  ptmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .clr(cnt_clr),
    .halt(ctrl.halt), .limit(limit), .cnt(cnt), .wrap(wrap)
  );

  assign irq = ctrl.flag && ctrl.ie;

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq |-> (bus_addr != OFS_CTRL) || (bus_rdata[7] && bus_rdata[6])));
endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  ptmr_top u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] h, l;
    rd(3'd1, h); rd(3'd2, l);
    v = {h, l};
  endtask

  task automatic run_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] b; int v;
    rd(3'd0, b); chk("R1 ctrl", b, 8'h20);
    rd_cnt(v);   chk("R1 cnt", v, 0);
    rd(3'd3, b); chk("R1 limh", b, 8'hFF);
    rd(3'd4, b); chk("R1 liml", b, 8'hFF);
    chk("R1 irq", irq, 0);
    run_n(20);
    rd_cnt(v);   chk("R1 halted", v, 0);
    rd(3'd5, b); chk("R2 ofs5", b, 0);
    rd(3'd7, b); chk("R2 ofs7", b, 0);
  endtask

  task automatic t_ro;
    int v;
    wr(3'd1, 8'h55); wr(3'd2, 8'hAA);
    rd_cnt(v); chk("R11 cnt ro", v, 0);
  endtask

  task automatic t_rates;
    int v;
    wr(3'd0, 8'h12); run_n(11); rd_cnt(v); chk("R3 div4 n11", v, 2);
    run_n(1);        rd_cnt(v); chk("R3 div4 n12", v, 3);
    wr(3'd0, 8'h16); run_n(64); rd_cnt(v); chk("R3 div64", v, 1);
    wr(3'd0, 8'h17); run_n(127); rd_cnt(v); chk("R3 code7 n127", v, 1);
    run_n(1);        rd_cnt(v); chk("R3 code7 n128", v, 2);
  endtask

  task automatic t_halt;
    int v; logic [7:0] b;
    wr(3'd0, 8'h10); run_n(5); rd_cnt(v); chk("R4 div1", v, 5);
    wr(3'd0, 8'h20); run_n(10); rd_cnt(v); chk("R6 held", v, 6);
    rd(3'd0, b); chk("R2 ctrl halted", b, 8'h20);
    wr(3'd0, 8'h00); run_n(4); rd_cnt(v); chk("R6 resume", v, 10);
  endtask

  task automatic t_strobe;
    int v; logic [7:0] b;
    wr(3'd0, 8'h12); run_n(6); rd_cnt(v); chk("R7 pre", v, 1);
    wr(3'd0, 8'h12); run_n(3); rd_cnt(v); chk("R7 cleared", v, 0);
    run_n(1); rd_cnt(v); chk("R7 presc cleared", v, 1);
    rd(3'd0, b); chk("R7 not stored", b, 8'h02);
  endtask

  task automatic t_limit;
    logic [7:0] b;
    wr(3'd0, 8'h20);
    wr(3'd3, 8'h12); rd(3'd3, b); chk("R12 limh", b, 8'h12);
    rd(3'd4, b); chk("R12 liml kept", b, 8'hFF);
    wr(3'd4, 8'h34); rd(3'd4, b); chk("R12 liml", b, 8'h34);
    rd(3'd3, b); chk("R12 limh kept", b, 8'h12);
    wr(3'd3, 8'h00); wr(3'd4, 8'h03);
  endtask

  task automatic t_wrap;
    int v; logic [7:0] b;
    wr(3'd0, 8'h10); run_n(3); rd_cnt(v); chk("R5 at limit", v, 3);
    rd(3'd0, b); chk("R5 no flag yet", b[7], 0);
    run_n(1); rd_cnt(v); chk("R5 wrapped", v, 0);
    rd(3'd0, b); chk("R5 flag", b[7], 1);
    chk("R10 irq off ie0", irq, 0);
    wr(3'd0, 8'hE0); chk("R10 irq on", irq, 1);
    wr(3'd0, 8'h20); chk("R8 cleared", irq, 0);
    rd(3'd0, b); chk("R8 flag 0", b[7], 0);
  endtask

  task automatic t_race;
    int v; logic [7:0] b;
    wr(3'd0, 8'h10); run_n(3);
    wr(3'd0, 8'h40);
    rd(3'd0, b); chk("R9 set wins", b[7], 1);
    chk("R10 irq", irq, 1);
    wr(3'd0, 8'h60);
    rd(3'd0, b); chk("R8 clear", b[7], 0);
    rd_cnt(v); chk("R4 after wrap", v, 1);
    wr(3'd0, 8'hE0);
    rd(3'd0, b); chk("R8 write1 no effect", b[7], 0);
    chk("R10 irq low", irq, 0);
  endtask

  initial begin
    run_n(3);
    rst_n = 1;
    run_n(5);
    t_reset; t_ro; t_rates; t_halt; t_strobe; t_limit; t_wrap; t_race;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule